// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block collects 72 level-sensitive interrupt sources into three groups: eight top-level sources and two banks of 32 sources each, called bank A and bank B. Each source has its own enable bit. Software never needs a read-modify-write to change an enable. Writing ones to a group's set address turns those enables on. Writing ones to the group's clear address turns them off. In both cases, zero bits leave their enables as they are.

A pending bit is a source level gated by its enable. Software reads one masked pending word per bank and a top-level summary word. The summary word holds the eight top-level sources, one "any pending" flag per bank, and direct copies of eleven frequently used bank bits. These copies let a handler often find its source with a single read. A single `irq` line is the OR of every masked pending bit.

The port is a plain 32-bit register interface: a one-cycle write strobe and a combinational read. A 32-bit fast-route register is provided as storage only.

Top module: `intc_regs`

## Requirements
- R1: After reset, all enables and the fast-route register are zero, so `irq` is low and every mapped register reads zero.
- R2: A write to a set address (0x10 bank A, 0x14 bank B, 0x18 top group) sets each enable whose data bit is 1. Enables whose data bit is 0 keep their value. The top group uses data bits 7:0.
- R3: A write to a clear address (0x1C bank A, 0x20 bank B, 0x24 top group) clears each enable whose data bit is 1. Enables whose data bit is 0 keep their value.
- R4: Address 0x04 reads bank A sources ANDed with their enables. Address 0x08 does the same for bank B. Bits 7:0 of address 0x00 read the top-group sources ANDed with their enables.
- R5: In the word at 0x00, bit 8 is 1 when any masked bank A bit is set, and bit 9 is 1 when any masked bank B bit is set.
- R6: In the word at 0x00, bits 10 to 14 copy masked bank A bits 7, 9, 10, 18 and 19. Bits 15 to 20 copy masked bank B bits 21, 22, 23, 24, 25 and 30. Bits 31:21 read zero.
- R7: `irq` is 1 exactly when at least one masked pending bit in any group is 1. It follows source and enable changes with no added register stage.
- R8: Reading a group's set address or its clear address returns that group's current enables, zero-extended.
- R9: The fast-route register at 0x0C is a 32-bit read/write store. Writing it changes no enable, pending bit or `irq`.
- R10: Any other address reads zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_top | input | 8 | Top-group source levels |
| src_a | input | 32 | Bank A source levels |
| src_b | input | 32 | Bank B source levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default `ADDR_W` of 8. With that width, every mapped offset is reachable, along with misaligned and unmapped addresses up to 0xFF, which exercises the zero-read and ignored-write cases.

Random mixes of set, clear, fast-route and stray writes run against random source patterns. These reach overlapping set/clear masks and the case where a single source is the only thing holding `irq` high. A directed walk exercises every shortcut copy position one at a time.

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [7:0]        src_top,
  input  logic [31:0]       src_a,
  input  logic [31:0]       src_b,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_SUM   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PA    = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PB    = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_SETA  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_SETB  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_SETT  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_CLRA  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CLRB  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CLRT  = ADDR_W'(8'h24);

  logic [7:0]  en_top;
  logic [31:0] en_a, en_b, route_q;
  logic [7:0]  pt;
  logic [31:0] pa, pb, sum_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_top  <= '0;
      en_a    <= '0;
      en_b    <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_SETA:  en_a    <= en_a | wdata;
        A_SETB:  en_b    <= en_b | wdata;
        A_SETT:  en_top  <= en_top | wdata[7:0];
        A_CLRA:  en_a    <= en_a & ~wdata;
        A_CLRB:  en_b    <= en_b & ~wdata;
        A_CLRT:  en_top  <= en_top & ~wdata[7:0];
        A_ROUTE: route_q <= wdata;
        default: ;
      endcase
    end
  end

  assign pt = src_top & en_top;
  assign pa = src_a & en_a;
  assign pb = src_b & en_b;

  assign sum_w = {11'b0, pb[30], pb[25], pb[24], pb[23], pb[22], pb[21],
                  pa[19], pa[18], pa[10], pa[9], pa[7], |pb, |pa, pt};

  assign irq = |{pt, pa, pb};

  always_comb begin
    case (addr)
      A_SUM:           rdata = sum_w;
      A_PA:            rdata = pa;
      A_PB:            rdata = pb;
      A_ROUTE:         rdata = route_q;
      A_SETA, A_CLRA:  rdata = en_a;
      A_SETB, A_CLRB:  rdata = en_b;
      A_SETT, A_CLRT:  rdata = {24'b0, en_top};
      default:         rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_regs_chk.sv
`timescale 1ns/1ps
module intc_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [7:0]        src_top,
  input logic [31:0]       src_a,
  input logic [31:0]       src_b,
  input logic              irq,
  input logic [7:0]        en_top,
  input logic [31:0]       en_a,
  input logic [31:0]       en_b,
  input logic [31:0]       route_q
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (en_a == 0 && en_b == 0 && en_top == 0 && route_q == 0));

  assert_set_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h10)) |=> ((en_a & $past(wdata)) == $past(wdata)));

  assert_clear_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h20)) |=> ((en_b & $past(wdata)) == 0));

  assert_clear_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h1C)) |=> ((en_a & ~$past(wdata)) == ($past(en_a) & ~$past(wdata))));

  assert_irq_needs_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|{src_top, src_a, src_b}));

  assert_route_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h0C)) |=> ($stable(en_a) && $stable(en_b) && $stable(en_top)));

  assert_stray_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > ADDR_W'(8'h24)) |=> ($stable(en_a) && $stable(en_b) && $stable(en_top) && $stable(route_q)));
endmodule

bind intc_regs intc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .src_top(src_top), .src_a(src_a), .src_b(src_b), .irq(irq),
  .en_top(en_top), .en_a(en_a), .en_b(en_b), .route_q(route_q)
);

// File: tb/test_intc_regs.sv
`timescale 1ns/1ps
module test_intc_regs;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] src_top = 0;
  logic [31:0] src_a = 0, src_b = 0;
  logic irq;

  int vectors = 0, misses = 0;
  logic [7:0]  m_et = 0;
  logic [31:0] m_ea = 0, m_eb = 0, m_rt = 0;

  always #10 clk = ~clk;

  intc_regs #(.ADDR_W(AW)) i_intc_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_top(src_top), .src_a(src_a), .src_b(src_b), .irq(irq));

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [31:0] pa, pb, s;
    int amap[5] = '{7, 9, 10, 18, 19};
    int bmap[6] = '{21, 22, 23, 24, 25, 30};
    pa = src_a & m_ea;
    pb = src_b & m_eb;
    s = 0;
    s[7:0] = src_top & m_et;
    s[8] = pa != 0;
    s[9] = pb != 0;
    for (int i = 0; i < 5; i++) s[10+i] = pa[amap[i]];
    for (int i = 0; i < 6; i++) s[15+i] = pb[bmap[i]];
    case (a)
      8'h00: return s;
      8'h04: return pa;
      8'h08: return pb;
      8'h0C: return m_rt;
      8'h10, 8'h1C: return m_ea;
      8'h14, 8'h20: return m_eb;
      8'h18, 8'h24: return {24'b0, m_et};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      8'h00: return "R5/R6";
      8'h04, 8'h08: return "R4";
      8'h0C: return "R9";
      8'h10, 8'h14, 8'h18: return "R2/R8";
      8'h1C, 8'h20, 8'h24: return "R3/R8";
      default: return "R10";
    endcase
  endfunction

  task automatic write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      8'h10: m_ea |= d;
      8'h14: m_eb |= d;
      8'h18: m_et |= d[7:0];
      8'h1C: m_ea &= ~d;
      8'h20: m_eb &= ~d;
      8'h24: m_et &= ~d[7:0];
      8'h0C: m_rt = d;
      default: ;
    endcase
  endtask

  task automatic check_rd(input logic [AW-1:0] a, input string tag);
    logic [31:0] e;
    addr = a;
    #1;
    e = exp_read(a);
    vectors++;
    if (rdata !== e) begin
      misses++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, rdata, e);
    end
  endtask

  task automatic check_irq(input string tag);
    logic e;
    #1;
    e = ((src_top & m_et) != 0) || ((src_a & m_ea) != 0) || ((src_b & m_eb) != 0);
    vectors++;
    if (irq !== e) begin
      misses++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  logic [AW-1:0] addr_list[11] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                   8'h18, 8'h1C, 8'h20, 8'h24, 8'h40};

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    src_top = 8'hFF; src_a = '1; src_b = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state with every source high
    for (int i = 0; i < 11; i++) check_rd(addr_list[i], "R1");
    check_irq("R1");

    // R2 / R3: partial set and clear keep other bits
    write(8'h10, 32'h0000_F0F0);
    write(8'h10, 32'h0000_0F00);
    check_rd(8'h10, "R2");
    write(8'h1C, 32'h0000_00F0);
    check_rd(8'h1C, "R3");
    check_rd(8'h04, "R4");
    write(8'h24, 32'hFFFF_FFFF);
    write(8'h18, 32'hFFFF_FF05);
    check_rd(8'h24, "R8");

    // R6: walk each shortcut position alone
    write(8'h1C, '1); write(8'h20, '1); write(8'h24, '1);
    write(8'h10, '1); write(8'h14, '1);
    for (int i = 0; i < 32; i++) begin
      src_top = 0; src_a = 32'h1 << i; src_b = 0;
      check_rd(8'h00, "R6"); check_irq("R7");
      src_a = 0; src_b = 32'h1 << i;
      check_rd(8'h00, "R6"); check_irq("R7");
    end

    // R7: single enabled source holds irq, removed by clear
    src_a = 0; src_b = 32'h8000_0000; src_top = 0;
    check_irq("R7");
    write(8'h20, 32'h8000_0000);
    check_irq("R7");
    check_rd(8'h00, "R5");

    // R9: fast-route write leaves enables and irq alone
    write(8'h0C, 32'hDEAD_BEEF);
    check_rd(8'h0C, "R9"); check_rd(8'h10, "R9"); check_irq("R9");

    // R10: stray and misaligned writes ignored
    write(8'h11, '1); write(8'h80, '1); write(8'hFC, 32'h1234);
    check_rd(8'h14, "R10"); check_rd(8'h80, "R10"); check_rd(8'h11, "R10");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      if ($urandom_range(0, 3) == 0) a = AW'($urandom_range(0, 255));
      else a = addr_list[$urandom_range(0, 10)];
      write(a, $urandom());
      src_top = 8'($urandom()); src_a = $urandom() & $urandom(); src_b = $urandom() & $urandom();
      a = addr_list[$urandom_range(0, 10)];
      check_rd(a, tag_of(a));
      check_irq("R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 200000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule